// File: doc/BRIEF.md
# Interrupt Status and Enable Unit

This block gathers six peripheral event strobes into one level interrupt line. Each strobe sets a sticky pending bit. Software sees the pending bits through a status register and clears them by writing ones to that register, so writing back a value it has just read clears exactly the bits it saw.

A per-source enable register selects which pending bits can raise the interrupt. A single global enable bit then gates the output line. A keyed soft-reset register emits a reset pulse of fixed length to the peripheral. While that pulse is high, the pending and enable registers are forced to zero.

The register port is a simple single-cycle write strobe with a combinational read. Writes take effect at the clock edge on which `we_i` is high. Reads return the register selected by `addr_i` in the same cycle.

Top module: `irq_status_unit`

## Requirements
- R1: Event inputs map to status bits in this order: bit0 mode fault, bit1 slave-mode fault, bit2 transmit FIFO empty, bit3 transmit underrun, bit4 receive FIFO full, bit5 receive overrun. A high `evt_i[n]` sets status bit n at the next clock edge. The bit stays set until it is cleared.
- R2: A write to the status register at offset 0x20 clears each status bit whose write-data bit is one. Bits written as zero are unchanged, so writing back a value just read clears every pending bit seen.
- R3: The enable register at offset 0x28 holds one enable per source in bits 5:0. A pending source whose enable bit is zero cannot drive `irq_o`.
- R4: The global enable is bit 31 of the register at offset 0x1c. `irq_o` equals that bit AND the OR over all sources of (status AND enable). It follows register state with no further delay.
- R5: `rdata_o` returns the register selected by `addr_i` in the same cycle. The soft-reset offset 0x40 and every unmapped offset read as zero.
- R6: If an event and a write-one-to-clear of the same bit occur in the same cycle, the bit ends up set.
- R7: A write of exactly 0x0000000a to offset 0x40 drives `soft_rst_o` high for RST_CYCLES consecutive cycles (default 4), starting in the cycle after the write. A write of any other value to that offset leaves `soft_rst_o` low.
- R8: Register bits with no function read as zero: bits 30:0 of the global enable register, and bits 31:6 of the status and enable registers.
- R9: While `soft_rst_o` is high, the status and enable registers are held at zero and incoming events are dropped. The global enable bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W (8) | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| evt_i | input | NUM_SRC (6) | Event strobes from the peripheral |
| irq_o | output | 1 | Interrupt line |
| soft_rst_o | output | 1 | Soft-reset pulse to the peripheral |

## Verification
The stimulus table sets events one at a time and in groups, then clears them with partial masks and with full write-backs. This separates sticky capture from a simple pass-through of the event lines, and shows that write-one-to-clear touches only the bits written as ones. The enable and global-enable patterns are switched while bits are pending, which shows whether each gate acts alone on `irq_o`. Directed cases cover an event that collides with its own clear, a wrong key against the right key with a count of pulse cycles, events dropped during the pulse, and reads of unmapped offsets.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned OFF_GIE  = 'h1c;
  localparam int unsigned OFF_ISR  = 'h20;
  localparam int unsigned OFF_IER  = 'h28;
  localparam int unsigned OFF_SRST = 'h40;
  localparam int unsigned GIE_BIT  = 31;
  localparam int unsigned REG_W    = 32;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_GIE, SEL_ISR, SEL_IER, SEL_SRST
  } reg_sel_e;
endpackage

// File: rtl/irq_sticky_status.sv
module irq_sticky_status #(
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic               hold_zero_i,
  output logic [NUM_SRC-1:0] status_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          status_o[g] <= 1'b0;
      else if (hold_zero_i) status_o[g] <= 1'b0;
      else if (set_i[g])    status_o[g] <= 1'b1;  // set beats clear
      else if (clr_i[g])    status_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_key_pulse.sv
module irq_key_pulse #(
  parameter int unsigned    DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY = 'h0a,
  parameter int unsigned    CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              pulse_o
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             key_hit;

  assign key_hit = wr_i && (wdata_i == KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (key_hit)       cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 6,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned RST_CYCLES = 4,
  parameter logic [31:0] RST_KEY    = 32'h0000_000a
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic               irq_o,
  output logic               soft_rst_o
);
  localparam int unsigned PAD_W = REG_W - NUM_SRC;

  reg_sel_e           sel;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] ier_q;
  logic               gie_q;
  logic [NUM_SRC-1:0] clr_mask;

  always_comb begin
    if      (addr_i == ADDR_W'(OFF_GIE))  sel = SEL_GIE;
    else if (addr_i == ADDR_W'(OFF_ISR))  sel = SEL_ISR;
    else if (addr_i == ADDR_W'(OFF_IER))  sel = SEL_IER;
    else if (addr_i == ADDR_W'(OFF_SRST)) sel = SEL_SRST;
    else                                  sel = SEL_NONE;
  end

  assign clr_mask = (we_i && sel == SEL_ISR) ? wdata_i[NUM_SRC-1:0] : '0;

  irq_sticky_status #(.NUM_SRC(NUM_SRC)) i_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (evt_i),
    .clr_i       (clr_mask),
    .hold_zero_i (soft_rst_o),
    .status_o    (status_q)
  );

  irq_key_pulse #(.DATA_W(REG_W), .KEY(RST_KEY), .CYCLES(RST_CYCLES)) i_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (we_i && sel == SEL_SRST),
    .wdata_i (wdata_i),
    .pulse_o (soft_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      ier_q <= '0;
    else if (soft_rst_o)              ier_q <= '0;
    else if (we_i && sel == SEL_IER)  ier_q <= wdata_i[NUM_SRC-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      gie_q <= 1'b0;
    else if (we_i && sel == SEL_GIE)  gie_q <= wdata_i[GIE_BIT];
  end

  always_comb begin
    unique case (sel)
      SEL_GIE: rdata_o = {gie_q, 31'b0};
      SEL_ISR: rdata_o = {{PAD_W{1'b0}}, status_q};
      SEL_IER: rdata_o = {{PAD_W{1'b0}}, ier_q};
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = gie_q & (|(status_q & ier_q));
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
  parameter int unsigned NUM_SRC = 6,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               we_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [31:0]        wdata_i,
  input logic [NUM_SRC-1:0] evt_i,
  input logic               irq_o,
  input logic               soft_rst_o,
  input logic [NUM_SRC-1:0] status_q,
  input logic [NUM_SRC-1:0] ier_q,
  input logic               gie_q
);
  // R1
  evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|evt_i) && !soft_rst_o) |=> ((status_q & $past(evt_i)) == $past(evt_i)));

  // R1
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(evt_i)) == '0));

  // R2
  w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'('h20) && evt_i == '0 && !soft_rst_o)
    |=> (status_q == ($past(status_q) & ~$past(wdata_i[NUM_SRC-1:0]))));

  // R4
  gie_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_q |-> !irq_o);

  // R3
  mask_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & ier_q) == '0) |-> !irq_o);

  // R7
  key_good_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'('h40) && wdata_i == 32'h0000_000a) |=> soft_rst_o);

  // R7
  key_bad_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'('h40) && wdata_i != 32'h0000_000a && !soft_rst_o)
    |=> !soft_rst_o);

  // R9
  pulse_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> (status_q == '0 && ier_q == '0));
endmodule

bind irq_status_unit irq_status_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .evt_i      (evt_i),
  .irq_o      (irq_o),
  .soft_rst_o (soft_rst_o),
  .status_q   (status_q),
  .ier_q      (ier_q),
  .gie_q      (gie_q)
);

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  localparam logic [7:0] A_GIE = 8'h1c, A_ISR = 8'h20, A_IER = 8'h28, A_SRST = 8'h40;
  localparam int unsigned PULSE = 4;

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [5:0]  evt;
    logic [7:0]  chk;
    logic [31:0] exp;
    logic        irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b1, A_IER,  32'h0000_003f, 6'h00, A_IER, 32'h0000_003f, 1'b0, 4'd3}, // R3
    '{1'b0, A_ISR,  32'h0,         6'h05, A_ISR, 32'h0000_0005, 1'b0, 4'd1}, // R1
    '{1'b1, A_GIE,  32'h8000_0000, 6'h00, A_GIE, 32'h8000_0000, 1'b1, 4'd4}, // R4
    '{1'b1, A_GIE,  32'hffff_ffff, 6'h00, A_GIE, 32'h8000_0000, 1'b1, 4'd8}, // R8
    '{1'b1, A_ISR,  32'h0000_0001, 6'h00, A_ISR, 32'h0000_0004, 1'b1, 4'd2}, // R2
    '{1'b1, A_IER,  32'h0000_0003, 6'h00, A_ISR, 32'h0000_0004, 1'b0, 4'd3}, // R3
    '{1'b1, A_IER,  32'hffff_ffff, 6'h00, A_IER, 32'h0000_003f, 1'b1, 4'd8}, // R8
    '{1'b1, A_ISR,  32'h0000_0004, 6'h04, A_ISR, 32'h0000_0004, 1'b1, 4'd6}, // R6
    '{1'b0, A_ISR,  32'h0,         6'h38, A_ISR, 32'h0000_003c, 1'b1, 4'd1}, // R1
    '{1'b1, A_ISR,  32'h0000_003c, 6'h00, A_ISR, 32'h0000_0000, 1'b0, 4'd2}, // R2
    '{1'b0, A_ISR,  32'h0,         6'h02, A_ISR, 32'h0000_0002, 1'b1, 4'd1}, // R1
    '{1'b1, A_GIE,  32'h0000_0000, 6'h00, A_GIE, 32'h0000_0000, 1'b0, 4'd4}, // R4
    '{1'b1, A_SRST, 32'h0000_000b, 6'h00, A_ISR, 32'h0000_0002, 1'b0, 4'd7}  // R7
  };

  logic        clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [5:0]  evt = '0;
  logic        irq, srst;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .evt_i(evt), .irq_o(irq), .soft_rst_o(srst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d; tick(); we = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a; #1; check(req, rdata, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hi;
    logic first;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    rd_chk("reset R4", A_GIE, 32'h0);
    rd_chk("reset R1", A_ISR, 32'h0);
    rd_chk("reset R3", A_IER, 32'h0);
    check("reset irq R4", {31'b0, irq}, 32'h0);
    check("reset pulse R7", {31'b0, srst}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      we = VECS[k].we; addr = VECS[k].addr; wdata = VECS[k].wdata; evt = VECS[k].evt;
      tick();
      we = 1'b0; evt = '0; wdata = '0;
      rd_chk($sformatf("vec%0d data R%0d", k, VECS[k].req), VECS[k].chk, VECS[k].exp);
      check($sformatf("vec%0d irq R%0d", k, VECS[k].req), {31'b0, irq}, {31'b0, VECS[k].irq});
    end

    // R5: soft-reset offset and unmapped offsets read zero
    rd_chk("R5 srst read", A_SRST, 32'h0);
    rd_chk("R5 unmapped", 8'h30, 32'h0);
    rd_chk("R5 unmapped hi", 8'hfc, 32'h0);

    // R7: wrong key leaves pulse low
    wr(A_SRST, 32'h0000_010a);
    hi = 0;
    for (int i = 0; i < 6; i++) begin #1; if (srst) hi++; tick(); end
    check("R7 bad key", hi, 0);

    wr(A_GIE, 32'h8000_0000);
    addr = A_ISR; #1;
    check("R4 irq on", {31'b0, irq}, 32'h1);

    // R7/R9: correct key, events during pulse dropped
    we = 1'b1; addr = A_SRST; wdata = 32'h0000_000a; tick();
    we = 1'b0; wdata = '0; evt = 6'h3f;
    hi = 0; first = 1'b0;
    for (int i = 0; i < PULSE + 4; i++) begin
      #1;
      if (srst) hi++;
      if (i == 0) first = srst;
      if (i == 1) evt = '0;
      tick();
    end
    check("R7 pulse first", {31'b0, first}, 32'h1);
    check("R7 pulse length", hi, PULSE);
    rd_chk("R9 isr cleared", A_ISR, 32'h0);
    rd_chk("R9 ier cleared", A_IER, 32'h0);
    rd_chk("R9 gie kept", A_GIE, 32'h8000_0000);
    check("R9 irq low", {31'b0, irq}, 32'h0);

    // R1: capture resumes after pulse
    evt = 6'h10; tick(); evt = '0;
    rd_chk("R1 post pulse", A_ISR, 32'h0000_0010);
    check("R3 masked after pulse", {31'b0, irq}, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule